// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard keeper for a small out-of-order pipeline with five functional units. Unit 0 is the integer/load unit, units 1 and 2 are multipliers, unit 3 is the adder and unit 4 is the divider. Each cycle it may accept one decoded instruction. The instruction carries a unit class, an operation code, a destination register and two source registers. The block decides in which cycle each instruction may issue to a unit, read its operands and write its result. The datapath starts the arithmetic once operands are read. It reports the end of execution on a per-unit done line.

The block keeps one status entry per functional unit and one owner entry per architectural register. An instruction moves through four phases: issue, operand read, execution and result write. Each phase is gated by its own check against those tables, so instructions can finish out of program order. Issue stalls on a structural conflict or on an output dependence. Operand read waits on true dependences. Result write waits on anti-dependences.

Top module: `sb_scoreboard`

## Requirements
- R1: While reset is asserted and after it is released, all units are idle and no register has a pending writer. With no input, `iss_grant`, `rd_grant` and `wr_grant` stay zero.
- R2: The unit class encodings are 0 for integer (unit 0), 1 for multiply (units 1 and 2), 2 for add (unit 3) and 3 for divide (unit 4). A valid instruction issues in the same cycle (`iss_grant` high) to the lowest-numbered idle unit of its class, and that number appears on `iss_unit`.
- R3: When every unit of the requested class is busy, `iss_grant` stays low and no state changes.
- R4: While a busy unit has the destination register as its pending result, `iss_grant` stays low (output-dependence stall).
- R5: An issued unit gets `rd_grant` at the earliest one cycle after issue, and only when both sources are ready. A source is ready when no unit owed it at issue, or when its producing unit has since written it. The read grant then comes one cycle after the producer's `wr_grant`.
- R6: A unit gets exactly one `rd_grant` per instruction. Its `ex_done` bit has no effect unless the unit is executing, which means after its read grant and before its done.
- R7: Once `ex_done` is seen for an executing unit, `wr_grant` for that unit may be given from the next cycle on. With that grant, `wr_reg` carries the unit's destination register.
- R8: A unit's write stalls while another unit has been granted issue but not operand read, and still holds the destination register as a source that was ready at its issue (anti-dependence).
- R9: At most one `wr_grant` bit is high per cycle. Among units able to write, the lowest-numbered one wins.
- R10: After its write, a unit is idle and may be issued again on the next cycle, and its destination register is no longer pending.
- R11: While a unit is busy, its slice `fu_op[u*OPW +: OPW]` holds the operation code it was issued with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_cls | input | 2 | Unit class of the instruction |
| in_op | input | OPW | Operation code |
| in_dst | input | log2(NREG) | Destination register |
| in_src1 | input | log2(NREG) | First source register |
| in_src2 | input | log2(NREG) | Second source register |
| ex_done | input | NFU | Per-unit end of execution |
| iss_grant | output | 1 | Instruction accepted this cycle |
| iss_unit | output | log2(NFU) | Unit receiving the instruction |
| rd_grant | output | NFU | Per-unit permission to read operands |
| wr_grant | output | NFU | Per-unit permission to write the result (one-hot or zero) |
| wr_reg | output | log2(NREG) | Register written under `wr_grant` |
| fu_op | output | NFU*OPW | Operation code held by each unit |

## Verification
Directed sequences separate the stall causes from each other. A third multiply with both multipliers busy exercises the structural stall, and an integer instruction targeting a pending register exercises the output-dependence stall. A consumer waits on a producer for the true-dependence check. A divide result sits behind an adder that still has to read the old value for the anti-dependence check. Done pulses sent to a unit still waiting for operands show they are ignored. Simultaneous completions show the fixed write priority. A long run of random instructions uses only eight registers, so hazards are dense, and adds sparse random done pulses. Every grant in that run is compared each cycle against an independent bench model of the four-phase rules, which catches ordering errors that no directed case reaches.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_EXEC  = 2'd2,
      PH_WRITE = 2'd3
   } phase_e;

   localparam logic [1:0] CL_INT = 2'd0;
   localparam logic [1:0] CL_MUL = 2'd1;
   localparam logic [1:0] CL_ADD = 2'd2;
   localparam logic [1:0] CL_DIV = 2'd3;

endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
   import sbd_pkg::*;
#(
   parameter int N_INT = 1,
   parameter int N_MUL = 2,
   parameter int N_ADD = 1,
   parameter int N_DIV = 1,
   parameter int NFU   = N_INT + N_MUL + N_ADD + N_DIV,
   parameter int UW    = 3
) (
   input  logic [NFU-1:0] busy,
   input  logic [1:0]     cls,
   output logic           found,
   output logic [UW-1:0]  unit
);

   localparam int MUL_BASE = N_INT;
   localparam int ADD_BASE = N_INT + N_MUL;
   localparam int DIV_BASE = N_INT + N_MUL + N_ADD;

   function automatic logic [1:0] class_of(input int idx);
      if (idx < MUL_BASE)      return CL_INT;
      else if (idx < ADD_BASE) return CL_MUL;
      else if (idx < DIV_BASE) return CL_ADD;
      else                     return CL_DIV;
   endfunction

   always_comb begin
      found = 1'b0;
      unit  = '0;
      for (int u = 0; u < NFU; u++) begin
         if (!found && !busy[u] && (class_of(u) == cls)) begin
            found = 1'b1;
            unit  = UW'(u);
         end
      end
   end

endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
   import sbd_pkg::*;
#(
   parameter int RW  = 5,
   parameter int UW  = 3,
   parameter int OPW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           issue_sel,
   input  logic [OPW-1:0] in_op,
   input  logic [RW-1:0]  in_dst,
   input  logic [RW-1:0]  in_src1,
   input  logic [RW-1:0]  in_src2,
   input  logic           src1_pend,
   input  logic [UW-1:0]  src1_unit,
   input  logic           src2_pend,
   input  logic [UW-1:0]  src2_unit,
   input  logic           rd_take,
   input  logic           ex_done,
   input  logic           wr_take,
   input  logic           bc_valid,
   input  logic [UW-1:0]  bc_unit,
   output phase_e         ph,
   output logic [OPW-1:0] op,
   output logic [RW-1:0]  fi,
   output logic [RW-1:0]  fj,
   output logic [RW-1:0]  fk,
   output logic           rj,
   output logic           rk
);

   logic [UW-1:0] qj, qk;
   logic          qj_v, qk_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         op   <= '0;
         fi   <= '0;
         fj   <= '0;
         fk   <= '0;
         qj   <= '0;
         qk   <= '0;
         qj_v <= 1'b0;
         qk_v <= 1'b0;
         rj   <= 1'b0;
         rk   <= 1'b0;
      end else if (issue_sel) begin
         ph   <= PH_READ;
         op   <= in_op;
         fi   <= in_dst;
         fj   <= in_src1;
         fk   <= in_src2;
         qj   <= src1_unit;
         qk   <= src2_unit;
         qj_v <= src1_pend;
         qk_v <= src2_pend;
         rj   <= !src1_pend;
         rk   <= !src2_pend;
      end else begin
         unique case (ph)
            PH_READ: begin
               if (rd_take) begin
                  rj <= 1'b0;
                  rk <= 1'b0;
                  ph <= PH_EXEC;
               end else if (bc_valid) begin
                  if (qj_v && (qj == bc_unit)) begin
                     rj   <= 1'b1;
                     qj_v <= 1'b0;
                  end
                  if (qk_v && (qk == bc_unit)) begin
                     rk   <= 1'b1;
                     qk_v <= 1'b0;
                  end
               end
            end
            PH_EXEC: begin
               if (ex_done) ph <= PH_WRITE;
            end
            PH_WRITE: begin
               if (wr_take) ph <= PH_IDLE;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sb_regstat.sv
module sb_regstat #(
   parameter int NREG = 32,
   parameter int RW   = 5,
   parameter int UW   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     set_en,
   input  logic [RW-1:0]            set_reg,
   input  logic [UW-1:0]            set_unit,
   input  logic                     clr_en,
   input  logic [RW-1:0]            clr_reg,
   output logic [NREG-1:0]          pend,
   output logic [NREG-1:0][UW-1:0]  owner
);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[r]  <= 1'b0;
            owner[r] <= '0;
         end else if (set_en && (set_reg == RW'(r))) begin
            pend[r]  <= 1'b1;
            owner[r] <= set_unit;
         end else if (clr_en && (clr_reg == RW'(r))) begin
            pend[r]  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sb_wr_arb.sv
module sb_wr_arb #(
   parameter int NFU       = 5,
   parameter int RW        = 5,
   parameter int UW        = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [NFU-1:0]          is_wr,
   input  logic [NFU-1:0]          is_rd,
   input  logic [NFU-1:0][RW-1:0]  fi,
   input  logic [NFU-1:0][RW-1:0]  fj,
   input  logic [NFU-1:0][RW-1:0]  fk,
   input  logic [NFU-1:0]          rj,
   input  logic [NFU-1:0]          rk,
   output logic [NFU-1:0]          grant,
   output logic                    any,
   output logic [UW-1:0]           unit
);

   logic [NFU-1:0] cand;

   always_comb begin
      for (int u = 0; u < NFU; u++) begin
         cand[u] = is_wr[u];
         for (int f = 0; f < NFU; f++) begin
            if ((f != u) && is_rd[f] &&
                (((fj[f] == fi[u]) && rj[f]) || ((fk[f] == fi[u]) && rk[f])))
               cand[u] = 1'b0;
         end
      end
   end

   if (LOW_FIRST) begin : g_low
      always_comb begin
         grant = '0;
         any   = 1'b0;
         unit  = '0;
         for (int u = 0; u < NFU; u++) begin
            if (!any && cand[u]) begin
               any      = 1'b1;
               unit     = UW'(u);
               grant[u] = 1'b1;
            end
         end
      end
   end else begin : g_high
      always_comb begin
         grant = '0;
         any   = 1'b0;
         unit  = '0;
         for (int u = NFU - 1; u >= 0; u--) begin
            if (!any && cand[u]) begin
               any      = 1'b1;
               unit     = UW'(u);
               grant[u] = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
   import sbd_pkg::*;
#(
   parameter int NREG         = 32,
   parameter int OPW          = 4,
   parameter int N_INT        = 1,
   parameter int N_MUL        = 2,
   parameter int N_ADD        = 1,
   parameter int N_DIV        = 1,
   parameter bit WR_LOW_FIRST = 1'b1,
   localparam int NFU = N_INT + N_MUL + N_ADD + N_DIV,
   localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int UW  = (NFU > 1) ? $clog2(NFU) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [1:0]         in_cls,
   input  logic [OPW-1:0]     in_op,
   input  logic [RW-1:0]      in_dst,
   input  logic [RW-1:0]      in_src1,
   input  logic [RW-1:0]      in_src2,
   input  logic [NFU-1:0]     ex_done,
   output logic               iss_grant,
   output logic [UW-1:0]      iss_unit,
   output logic [NFU-1:0]     rd_grant,
   output logic [NFU-1:0]     wr_grant,
   output logic [RW-1:0]      wr_reg,
   output logic [NFU*OPW-1:0] fu_op
);

   if (NREG < 2) begin : g_bad_nreg
      $error("sb_scoreboard: NREG must be at least 2");
   end
   if ((N_INT < 1) || (N_MUL < 1) || (N_ADD < 1) || (N_DIV < 1)) begin : g_bad_units
      $error("sb_scoreboard: every unit class needs at least one unit");
   end
   if (OPW < 1) begin : g_bad_opw
      $error("sb_scoreboard: OPW must be positive");
   end

   phase_e                  ph [NFU];
   logic [NFU-1:0]          busy, is_rd, is_wr, rj, rk;
   logic [NFU-1:0][RW-1:0]  fi, fj, fk;
   logic [NFU-1:0][OPW-1:0] op_q;
   logic [NREG-1:0]         pend;
   logic [NREG-1:0][UW-1:0] owner;
   logic                    unit_found, wr_any;
   logic [UW-1:0]           sel_unit, wr_unit;
   logic                    src1_pend, src2_pend;

   sb_issue_sel #(
      .N_INT(N_INT), .N_MUL(N_MUL), .N_ADD(N_ADD), .N_DIV(N_DIV),
      .NFU(NFU), .UW(UW)
   ) u_isel (
      .busy  (busy),
      .cls   (in_cls),
      .found (unit_found),
      .unit  (sel_unit)
   );

   assign iss_grant = in_valid && unit_found && !pend[in_dst];
   assign iss_unit  = sel_unit;

   assign src1_pend = pend[in_src1] && !(wr_any && (wr_reg == in_src1));
   assign src2_pend = pend[in_src2] && !(wr_any && (wr_reg == in_src2));

   for (genvar u = 0; u < NFU; u++) begin : g_fu
      sb_fu_entry #(.RW(RW), .UW(UW), .OPW(OPW)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .issue_sel (iss_grant && (sel_unit == UW'(u))),
         .in_op     (in_op),
         .in_dst    (in_dst),
         .in_src1   (in_src1),
         .in_src2   (in_src2),
         .src1_pend (src1_pend),
         .src1_unit (owner[in_src1]),
         .src2_pend (src2_pend),
         .src2_unit (owner[in_src2]),
         .rd_take   (rd_grant[u]),
         .ex_done   (ex_done[u]),
         .wr_take   (wr_grant[u]),
         .bc_valid  (wr_any),
         .bc_unit   (wr_unit),
         .ph        (ph[u]),
         .op        (op_q[u]),
         .fi        (fi[u]),
         .fj        (fj[u]),
         .fk        (fk[u]),
         .rj        (rj[u]),
         .rk        (rk[u])
      );
      assign busy[u]     = (ph[u] != PH_IDLE);
      assign is_rd[u]    = (ph[u] == PH_READ);
      assign is_wr[u]    = (ph[u] == PH_WRITE);
      assign rd_grant[u] = is_rd[u] && rj[u] && rk[u];
      assign fu_op[u*OPW +: OPW] = op_q[u];
   end

   sb_wr_arb #(
      .NFU(NFU), .RW(RW), .UW(UW), .LOW_FIRST(WR_LOW_FIRST)
   ) u_warb (
      .is_wr (is_wr),
      .is_rd (is_rd),
      .fi    (fi),
      .fj    (fj),
      .fk    (fk),
      .rj    (rj),
      .rk    (rk),
      .grant (wr_grant),
      .any   (wr_any),
      .unit  (wr_unit)
   );

   assign wr_reg = wr_any ? fi[wr_unit] : '0;

   sb_regstat #(.NREG(NREG), .RW(RW), .UW(UW)) u_rstat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (iss_grant),
      .set_reg  (in_dst),
      .set_unit (sel_unit),
      .clr_en   (wr_any),
      .clr_reg  (wr_reg),
      .pend     (pend),
      .owner    (owner)
   );

endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
   parameter int NFU = 5,
   parameter int UW  = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           iss_grant,
   input logic [UW-1:0]  iss_unit,
   input logic [NFU-1:0] rd_grant,
   input logic [NFU-1:0] wr_grant,
   input logic [NFU-1:0] busy
);

   AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_grant)); // R9

   AST_ISS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_grant |-> !busy[iss_unit]); // R2

   AST_ISS_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      iss_grant |=> busy[$past(iss_unit)]); // R2

   AST_RD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_grant & $past(rd_grant)) == '0); // R6

   AST_RD_WR_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_grant & wr_grant) == '0); // R7

   AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_grant & ~busy) == '0); // R7

endmodule

bind sb_scoreboard sb_scoreboard_chk #(.NFU(NFU), .UW(UW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_grant (iss_grant),
   .iss_unit  (iss_unit),
   .rd_grant  (rd_grant),
   .wr_grant  (wr_grant),
   .busy      (busy)
);

// File: tb/sb_scoreboard_tb_top.sv
module sb_scoreboard_tb_top;

   localparam int NFU = 5;
   localparam int RW  = 5;
   localparam int UW  = 3;
   localparam int OPW = 4;
   localparam int NR  = 32;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst_n;
   logic               in_valid;
   logic [1:0]         in_cls;
   logic [OPW-1:0]     in_op;
   logic [RW-1:0]      in_dst, in_src1, in_src2;
   logic [NFU-1:0]     ex_done;
   logic               iss_grant;
   logic [UW-1:0]      iss_unit;
   logic [NFU-1:0]     rd_grant, wr_grant;
   logic [RW-1:0]      wr_reg;
   logic [NFU*OPW-1:0] fu_op;

   sb_scoreboard dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
      .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
      .ex_done(ex_done), .iss_grant(iss_grant), .iss_unit(iss_unit),
      .rd_grant(rd_grant), .wr_grant(wr_grant), .wr_reg(wr_reg), .fu_op(fu_op)
   );

   int n_chk = 0;
   int n_bad = 0;

   // bench model: phase 0 idle, 1 wait read, 2 executing, 3 wait write
   int m_ph [NFU];
   int m_fi [NFU];
   int m_fj [NFU];
   int m_fk [NFU];
   int m_qj [NFU];
   int m_qk [NFU];
   int m_op [NFU];
   bit m_rj [NFU];
   bit m_rk [NFU];
   int m_rs [NR];

   bit             e_iss;
   int             e_unit;
   int             e_w;
   logic [NFU-1:0] e_rd, e_wr;

   function automatic int cls_lo(input int c);
      case (c)
         0: return 0;
         1: return 1;
         2: return 3;
         default: return 4;
      endcase
   endfunction

   function automatic int cls_hi(input int c);
      case (c)
         0: return 0;
         1: return 2;
         2: return 3;
         default: return 4;
      endcase
   endfunction

   task automatic model_reset();
      for (int u = 0; u < NFU; u++) begin
         m_ph[u] = 0; m_qj[u] = -1; m_qk[u] = -1;
         m_rj[u] = 0; m_rk[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0; m_op[u] = 0;
      end
      for (int r = 0; r < NR; r++) m_rs[r] = -1;
   endtask

   task automatic model_eval();
      bit blk;
      e_unit = -1;
      for (int u = cls_lo(int'(in_cls)); u <= cls_hi(int'(in_cls)); u++)
         if (m_ph[u] == 0 && e_unit < 0) e_unit = u;
      e_iss = in_valid && (e_unit >= 0) && (m_rs[in_dst] < 0);
      for (int u = 0; u < NFU; u++)
         e_rd[u] = (m_ph[u] == 1) && m_rj[u] && m_rk[u];
      e_w = -1;
      for (int u = 0; u < NFU; u++) begin
         if (e_w < 0 && m_ph[u] == 3) begin
            blk = 0;
            for (int f = 0; f < NFU; f++)
               if (f != u && m_ph[f] == 1 &&
                   ((m_fj[f] == m_fi[u] && m_rj[f]) || (m_fk[f] == m_fi[u] && m_rk[f])))
                  blk = 1;
            if (!blk) e_w = u;
         end
      end
      e_wr = (e_w >= 0) ? NFU'(1 << e_w) : '0;
   endtask

   task automatic model_update();
      bit s1p, s2p;
      int s1u, s2u;
      s1p = (m_rs[in_src1] >= 0) && !(e_w >= 0 && m_fi[e_w] == int'(in_src1));
      s2p = (m_rs[in_src2] >= 0) && !(e_w >= 0 && m_fi[e_w] == int'(in_src2));
      s1u = m_rs[in_src1];
      s2u = m_rs[in_src2];
      if (e_w >= 0) begin
         m_rs[m_fi[e_w]] = -1;
         m_ph[e_w] = 0;
         for (int f = 0; f < NFU; f++) begin
            if (m_ph[f] == 1 && !e_rd[f]) begin
               if (m_qj[f] == e_w) begin m_rj[f] = 1; m_qj[f] = -1; end
               if (m_qk[f] == e_w) begin m_rk[f] = 1; m_qk[f] = -1; end
            end
         end
      end
      for (int u = 0; u < NFU; u++) begin
         if (e_rd[u]) begin
            m_ph[u] = 2; m_rj[u] = 0; m_rk[u] = 0;
         end else if (m_ph[u] == 2 && ex_done[u]) begin
            m_ph[u] = 3;
         end
      end
      if (e_iss) begin
         m_ph[e_unit] = 1;
         m_fi[e_unit] = int'(in_dst);
         m_fj[e_unit] = int'(in_src1);
         m_fk[e_unit] = int'(in_src2);
         m_op[e_unit] = int'(in_op);
         m_qj[e_unit] = s1p ? s1u : -1;
         m_qk[e_unit] = s2p ? s2u : -1;
         m_rj[e_unit] = !s1p;
         m_rk[e_unit] = !s2p;
         m_rs[in_dst] = e_unit;
      end
   endtask

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic put(input int c, input int d, input int a, input int b, input int o);
      in_valid = 1'b1;
      in_cls   = 2'(c);
      in_dst   = RW'(d);
      in_src1  = RW'(a);
      in_src2  = RW'(b);
      in_op    = OPW'(o);
   endtask

   task automatic step(input string tag);
      #1;
      model_eval();
      chk(tag, "R2/R3/R4 iss_grant", int'(iss_grant), int'(e_iss));
      if (e_iss) chk(tag, "R2 iss_unit", int'(iss_unit), e_unit);
      chk(tag, "R5/R6 rd_grant", int'(rd_grant), int'(e_rd));
      chk(tag, "R8/R9 wr_grant", int'(wr_grant), int'(e_wr));
      if (e_w >= 0) chk(tag, "R7 wr_reg", int'(wr_reg), m_fi[e_w]);
      for (int u = 0; u < NFU; u++)
         if (m_ph[u] != 0) chk(tag, "R11 fu_op", int'(fu_op[u*OPW +: OPW]), m_op[u]);
      @(posedge clk);
      model_update();
      @(negedge clk);
      in_valid = 1'b0;
      ex_done  = '0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_cls = '0; in_op = '0;
      in_dst = '0; in_src1 = '0; in_src2 = '0; ex_done = '0;
      model_reset();
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1", "reset iss_grant", int'(iss_grant), 0);
      chk("R1", "reset rd_grant", int'(rd_grant), 0);
      chk("R1", "reset wr_grant", int'(wr_grant), 0);
      rst_n = 1'b1;
      @(negedge clk);
      step("R1");

      // structural and output-dependence stalls
      put(1, 1, 2, 3, 5);   step("R2");
      put(1, 4, 1, 3, 6);   step("R2");
      put(1, 5, 2, 2, 7);   step("R3");
      put(0, 4, 9, 9, 1);   step("R4");
      step("R5");
      ex_done = 5'b00100;   step("R6");
      ex_done = 5'b00100;   step("R6");
      ex_done = 5'b00010;   step("R7");
      repeat (3) step("R10");

      // anti-dependence: adder keeps reg 11 as an unread ready source
      put(2, 10, 11, 4, 2); step("R8");
      put(3, 11, 12, 12, 3); step("R8");
      repeat (4) begin ex_done = 5'b10000; step("R8"); end
      repeat (3) step("R8");
      repeat (3) begin ex_done = 5'b00100; step("R5"); end
      repeat (6) step("R8");
      repeat (4) begin ex_done = 5'b01000; step("R10"); end
      repeat (3) step("R10");

      // simultaneous completions
      put(0, 20, 21, 21, 8); step("R9");
      put(1, 22, 23, 23, 9); step("R9");
      put(3, 24, 25, 25, 10); step("R9");
      repeat (2) step("R9");
      ex_done = 5'b11111; step("R9");
      repeat (4) step("R9");
      repeat (10) begin ex_done = 5'b11111; step("R10"); end

      // dense random traffic over eight registers
      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 3 != 0)
            put(int'($urandom % 4), int'($urandom % 8), int'($urandom % 8),
                int'($urandom % 8), int'($urandom % 16));
         if ($urandom % 3 == 0) ex_done = NFU'($urandom);
         step("random");
      end
      repeat (30) begin ex_done = 5'b11111; step("R10"); end
      finish_run();
   end

endmodule